// File: doc/BRIEF.md
# Card Socket Control Register with Clock-Stop Qualifier

This block holds the control word for one card socket and decides when the card clock may be stopped or slowed. Software writes the socket supply requests through a small register port: a 3-bit request for the card core supply, a 3-bit request for the programming supply, and one mode bit. The request fields are also driven out directly to the power-switch logic. The block does not check the requested codes. Any code is stored and passed on as written.

The qualifier counts consecutive clocks on which the socket reports that it is idle. The count saturates at a threshold, which defaults to 8. While the count is full, the registered output `stop_ok` is raised. If the mode bit is 0, the host bus must also signal that it is about to stop its own clock. If the mode bit is 1, the host signal is ignored.

There are two synchronous active-low resets. The global reset clears everything. The bus reset always clears the qualifier. It clears the request fields only when power management is disabled.

Top module: `sock_ctl_qual`

## Requirements
- R1: After reset, `rd_data` reads 32'h0000_0400 and `stop_ok` is 0.
- R2: The read/write fields are: bit 7 for the clock-stop mode, bits 6:4 for the core-supply request, and bits 2:0 for the programming-supply request. A write with `wr_be[0]`=1 takes effect at the clock edge, and the new value appears on `rd_data` after that edge. Bits 31:11, 9:8 and 3 always read 0 and bit 10 always reads 1, whatever value is written.
- R3: A write with `wr_be[0]`=0 has no effect. Enables `wr_be[3:1]` are ignored.
- R4: Every 3-bit code is stored as written, reserved codes included, and is mirrored on `vcc_req` and `vpp_req`. The core-supply codes are: 000 off, 010 5 V, 011 3.3 V, 100 and 101 low-voltage options, and 001, 110, 111 reserved. The programming-supply codes are: 000 off, 001 12 V, 010 5 V, 011 3.3 V, 100 and 101 low-voltage options, and 110, 111 reserved.
- R5: `stop_ok` goes high at the clock edge that samples the 8th consecutive cycle with `sock_idle`=1, provided the qualification of R6 or R7 holds at that edge. It is never high before that edge.
- R6: When the mode bit is 0, `stop_ok` after an edge also requires `host_stop_pend`=1 at that edge.
- R7: When the mode bit is 1, `host_stop_pend` has no effect on `stop_ok`.
- R8: An edge that samples `sock_idle`=0 forces `stop_ok` to 0, and 8 fresh idle cycles are needed before it can rise again. The idle count saturates, so `stop_ok` stays high through an idle period of any length.
- R9: When `pm_en`=1, a bus reset leaves the fields unchanged. Writes are ignored while either reset is asserted.
- R10: The global reset always clears the fields. A bus reset clears them when `pm_en`=0.
- R11: Either reset forces `stop_ok` to 0 and restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| glob_rst_n | input | 1 | Global synchronous reset, active low |
| bus_rst_n | input | 1 | Bus synchronous reset, active low |
| pm_en | input | 1 | Power management enabled |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Write byte enables (only bit 0 used) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| vcc_req | output | 3 | Core-supply request field |
| vpp_req | output | 3 | Programming-supply request field |
| sock_idle | input | 1 | Socket reports idle this cycle |
| host_stop_pend | input | 1 | Host bus preparing to stop its clock |
| stop_ok | output | 1 | Card clock stop/slow permitted (registered) |

## Verification
A register write is visible on `rd_data`, `vcc_req` and `vpp_req` after the clock edge that takes the write. `stop_ok` changes at the same edge that samples `sock_idle`, `host_stop_pend` and the mode bit, with no added latency. The bench drives every input just after a falling edge and applies each rising edge to its own model. It then compares all outputs at the next falling edge, so each result is checked in the half-cycle after the edge that produces it. The mode bit used for the stop decision is the value held before any write at the same edge, and the model follows the same rule.

// File: rtl/sock_ctl_pkg.sv
// Package: shared field positions, the control-field record and its
// packing to the 32-bit register image. Assumes a single 32-bit register.
package sock_ctl_pkg;

    localparam int REG_W     = 32;
    localparam int ONE_BIT   = 10;
    localparam int MODE_BIT  = 7;
    localparam int VCC_LSB   = 4;
    localparam int VPP_LSB   = 0;
    localparam int FIELD_W   = 3;

    // Core-supply request codes
    typedef enum logic [2:0] {
        VCC_OFF   = 3'b000,
        VCC_RSV1  = 3'b001,
        VCC_5V    = 3'b010,
        VCC_3V3   = 3'b011,
        VCC_LOWA  = 3'b100,
        VCC_LOWB  = 3'b101,
        VCC_RSV6  = 3'b110,
        VCC_RSV7  = 3'b111
    } vcc_code_e;

    // Programming-supply request codes
    typedef enum logic [2:0] {
        VPP_OFF   = 3'b000,
        VPP_12V   = 3'b001,
        VPP_5V    = 3'b010,
        VPP_3V3   = 3'b011,
        VPP_LOWA  = 3'b100,
        VPP_LOWB  = 3'b101,
        VPP_RSV6  = 3'b110,
        VPP_RSV7  = 3'b111
    } vpp_code_e;

    typedef struct packed {
        logic                stop_mode;
        logic [FIELD_W-1:0]  vcc;
        logic [FIELD_W-1:0]  vpp;
    } ctl_t;

    localparam ctl_t CTL_CLEAR = '{stop_mode: 1'b0, vcc: 3'b000, vpp: 3'b000};

    // Build the full register image from the stored fields.
    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[ONE_BIT]                      = 1'b1;
        w[MODE_BIT]                     = c.stop_mode;
        w[VCC_LSB +: FIELD_W]           = c.vcc;
        w[VPP_LSB +: FIELD_W]           = c.vpp;
        return w;
    endfunction

    // Extract the writable fields from a write word.
    function automatic ctl_t word_to_ctl(input logic [7:0] b);
        ctl_t c;
        c.stop_mode = b[MODE_BIT];
        c.vcc       = b[VCC_LSB +: FIELD_W];
        c.vpp       = b[VPP_LSB +: FIELD_W];
        return c;
    endfunction

endpackage

// File: rtl/sock_ctl_reg.sv
// Control register: stores the mode bit and two supply request fields.
// Writes land on the low byte only, at the write edge, and are ignored while
// either reset is asserted. The global reset always clears. The bus reset
// clears only when power management is disabled, otherwise the fields hold.
// Assumes both resets are synchronous to clk.
module sock_ctl_reg
    import sock_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              glob_rst_n,
    input  logic              bus_rst_n,
    input  logic              pm_en,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output ctl_t              ctl_q,
    output logic [REG_W-1:0]  rd_data
);

    logic unused_wr_bits;
    logic take_wr;

    // Upper enables and data bits have no storage behind them.
    assign unused_wr_bits = ^{wr_be[3:1], wr_data[REG_W-1:8], wr_data[3]};

    // Write qualifier: strobe, low-byte enable, no reset in progress.
    assign take_wr = wr_en && wr_be[0] && glob_rst_n && bus_rst_n;

    // Field storage with reset-domain selection.
    always_ff @(posedge clk) begin
        if (!glob_rst_n) begin
            ctl_q <= CTL_CLEAR;
        end else if (!bus_rst_n) begin
            if (!pm_en) begin
                ctl_q <= CTL_CLEAR;
            end
        end else if (take_wr) begin
            ctl_q <= word_to_ctl(wr_data[7:0]);
        end
    end

    // Read image, visible the cycle after the write edge.
    assign rd_data = ctl_to_word(ctl_q);

    a_r9_pm_hold: assert property (@(posedge clk) disable iff (!glob_rst_n)
        (!bus_rst_n && pm_en) |=> $stable(ctl_q));

    a_r10_bus_clear: assert property (@(posedge clk) disable iff (!glob_rst_n)
        (!bus_rst_n && !pm_en) |=> (ctl_q == CTL_CLEAR));

    a_r3_no_low_be: assert property (@(posedge clk) disable iff (!glob_rst_n || !bus_rst_n)
        (wr_en && !wr_be[0]) |=> $stable(ctl_q));

endmodule

// File: rtl/sock_idle_cnt.sv
// Idle run counter: counts consecutive idle cycles, clears on a busy cycle
// and saturates at IDLE_THR. It also reports whether the count will be full
// after this edge, so the qualifier can act on the same edge.
// Assumes rst_n already combines every reset that must restart the run.
module sock_idle_cnt #(
    parameter int IDLE_THR = 8,
    localparam int CW      = $clog2(IDLE_THR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sock_idle,
    output logic [CW-1:0] cnt_q,
    output logic          full_nxt
);

    localparam logic [CW-1:0] THR_C = CW'(IDLE_THR);

    logic [CW-1:0] cnt_nxt;

    // Next count: clear when busy, hold at the threshold, else step.
    always_comb begin
        if (!sock_idle) begin
            cnt_nxt = '0;
        end else if (cnt_q == THR_C) begin
            cnt_nxt = cnt_q;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    assign full_nxt = (cnt_nxt == THR_C);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= THR_C);

    a_r8_cnt_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !sock_idle |=> (cnt_q == '0));

endmodule

// File: rtl/sock_stop_qual.sv
// Stop qualifier: registers the stop-permitted decision. It needs a full
// idle run and, in mode 0, the host clock-stop-pending input as well.
// Assumes full_nxt already includes the idle state of the current cycle.
module sock_stop_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic full_nxt,
    input  logic stop_mode,
    input  logic host_stop_pend,
    input  logic sock_idle,
    output logic stop_ok
);

    logic host_gate;

    // Host condition: waived in mode 1.
    assign host_gate = stop_mode || host_stop_pend;

    // Registered permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_ok <= 1'b0;
        end else begin
            stop_ok <= full_nxt && host_gate;
        end
    end

    a_r8_drop_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !sock_idle |=> !stop_ok);

    a_r6_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && !host_stop_pend) |=> !stop_ok);

endmodule

// File: rtl/sock_ctl_qual.sv
// Top: socket control register with card clock-stop qualifier. The register
// supplies the mode bit that selects local-only or host-gated stopping. Both
// resets restart the idle run, and the register chooses its own reset domain.
module sock_ctl_qual
    import sock_ctl_pkg::*;
#(
    parameter int IDLE_THR = 8
) (
    input  logic              clk,
    input  logic              glob_rst_n,
    input  logic              bus_rst_n,
    input  logic              pm_en,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [2:0]        vcc_req,
    output logic [2:0]        vpp_req,
    input  logic              sock_idle,
    input  logic              host_stop_pend,
    output logic              stop_ok
);

    localparam int CW = $clog2(IDLE_THR + 1);
    localparam logic [CW-1:0] THR_C = CW'(IDLE_THR);

    ctl_t          ctl;
    logic          any_rst_n;
    logic [CW-1:0] idle_cnt;
    logic          idle_full_nxt;

    // Either reset restarts the qualifier path.
    assign any_rst_n = glob_rst_n && bus_rst_n;

    sock_ctl_reg i_reg (
        .clk        (clk),
        .glob_rst_n (glob_rst_n),
        .bus_rst_n  (bus_rst_n),
        .pm_en      (pm_en),
        .wr_en      (wr_en),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .ctl_q      (ctl),
        .rd_data    (rd_data)
    );

    sock_idle_cnt #(.IDLE_THR(IDLE_THR)) i_cnt (
        .clk        (clk),
        .rst_n      (any_rst_n),
        .sock_idle  (sock_idle),
        .cnt_q      (idle_cnt),
        .full_nxt   (idle_full_nxt)
    );

    sock_stop_qual i_qual (
        .clk            (clk),
        .rst_n          (any_rst_n),
        .full_nxt       (idle_full_nxt),
        .stop_mode      (ctl.stop_mode),
        .host_stop_pend (host_stop_pend),
        .sock_idle      (sock_idle),
        .stop_ok        (stop_ok)
    );

    assign vcc_req = ctl.vcc;
    assign vpp_req = ctl.vpp;

    a_r5_full_count: assert property (@(posedge clk) disable iff (!any_rst_n)
        stop_ok |-> (idle_cnt == THR_C));

    a_r7_mode1_free: assert property (@(posedge clk) disable iff (!any_rst_n)
        (ctl.stop_mode && idle_full_nxt) |=> stop_ok);

endmodule

// File: tb/test_sock_ctl_qual.sv
// Bench: sweeps every low-byte write code, idle run lengths, both modes and
// both host states, and the reset-domain combinations, against its own model.
module test_sock_ctl_qual;

    logic        clk = 1'b0;
    logic        glob_rst_n, bus_rst_n, pm_en;
    logic        wr_en;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [2:0]  vcc_req, vpp_req;
    logic        sock_idle, host_stop_pend;
    logic        stop_ok;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // Model state
    bit       m_mode;
    bit [2:0] m_vcc, m_vpp;
    int       m_run;
    bit       m_stop;

    always #5 clk = ~clk;

    sock_ctl_qual i_sock_ctl_qual (
        .clk            (clk),
        .glob_rst_n     (glob_rst_n),
        .bus_rst_n      (bus_rst_n),
        .pm_en          (pm_en),
        .wr_en          (wr_en),
        .wr_be          (wr_be),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .vcc_req        (vcc_req),
        .vpp_req        (vpp_req),
        .sock_idle      (sock_idle),
        .host_stop_pend (host_stop_pend),
        .stop_ok        (stop_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word();
        return 32'h0000_0400 | (32'(m_mode) << 7) | (32'(m_vcc) << 4) | 32'(m_vpp);
    endfunction

    // Apply one rising edge to the model using the current inputs.
    task automatic model_edge();
        if (!glob_rst_n || !bus_rst_n) begin
            m_run  = 0;
            m_stop = 0;
        end else begin
            if (!sock_idle) m_run = 0;
            else if (m_run < 8) m_run = m_run + 1;
            m_stop = (m_run == 8) && (m_mode || host_stop_pend);
        end
        if (!glob_rst_n || (!bus_rst_n && !pm_en)) begin
            m_mode = 0; m_vcc = 0; m_vpp = 0;
        end else if (glob_rst_n && bus_rst_n && wr_en && wr_be[0]) begin
            m_mode = wr_data[7]; m_vcc = wr_data[6:4]; m_vpp = wr_data[2:0];
        end
    endtask

    // One cycle: inputs set at a falling edge, outputs checked at the next one.
    task automatic cyc(input string tag, input bit idle, input bit pend,
                       input bit we, input logic [31:0] d, input logic [3:0] be);
        sock_idle = idle; host_stop_pend = pend;
        wr_en = we; wr_data = d; wr_be = be;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " stop_ok"}, 32'(stop_ok), 32'(m_stop));
        chk({tag, " rd_data"}, rd_data, exp_word());
        chk({tag, " vcc_req"}, 32'(vcc_req), 32'(m_vcc));
        chk({tag, " vpp_req"}, 32'(vpp_req), 32'(m_vpp));
    endtask

    task automatic idle_cyc(input string tag, input bit idle, input bit pend);
        cyc(tag, idle, pend, 1'b0, 32'h0, 4'h0);
    endtask

    task automatic do_wr(input string tag, input logic [31:0] d, input logic [3:0] be);
        cyc(tag, 1'b0, 1'b0, 1'b1, d, be);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        glob_rst_n = 0; bus_rst_n = 0; pm_en = 0;
        wr_en = 0; wr_be = 0; wr_data = 0;
        sock_idle = 0; host_stop_pend = 0;
        m_mode = 0; m_vcc = 0; m_vpp = 0; m_run = 0; m_stop = 0;
        @(negedge clk);
        repeat (3) idle_cyc("R11 in reset", 1'b1, 1'b1);
        glob_rst_n = 1; bus_rst_n = 1;
        idle_cyc("R1 reset state", 1'b0, 1'b0);
        chk("R1 reset word", rd_data, 32'h0000_0400);

        // R2: read-only bits fixed, writable fields take the write
        do_wr("R2 all ones", 32'hFFFF_FFFF, 4'hF);
        chk("R2 image", rd_data, 32'h0000_04F7);
        do_wr("R2 all zeros", 32'h0000_0000, 4'hF);
        chk("R2 zero image", rd_data, 32'h0000_0400);

        // R3: no low-byte enable, upper enables only
        do_wr("R3 be high lanes", 32'hFFFF_FFFF, 4'hE);
        do_wr("R3 be none", 32'h0000_00FF, 4'h0);
        chk("R3 unchanged", rd_data, 32'h0000_0400);

        // R4: every low-byte code, reserved ones included
        for (int v = 0; v < 256; v++) begin
            do_wr("R4 code sweep", {24'hA5A5A5, 8'(v)}, 4'h1);
        end

        // R5 R6 R7 R8: run lengths across modes and host states
        for (int m = 0; m < 2; m++) begin
            do_wr("R2 set mode", 32'((m << 7) | 8'h23), 4'h1);
            for (int p = 0; p < 2; p++) begin
                for (int run = 0; run < 12; run++) begin
                    for (int k = 0; k < run; k++) idle_cyc(m ? "R7 run" : "R6 run", 1'b1, 1'(p));
                    idle_cyc("R8 busy", 1'b0, 1'(p));
                end
            end
        end

        // R8: saturation, long idle with mode 1
        do_wr("R2 mode1", 32'h0000_0080, 4'h1);
        for (int k = 0; k < 40; k++) idle_cyc("R8 saturate", 1'b1, 1'b0);
        chk("R8 still high", 32'(stop_ok), 32'h1);
        idle_cyc("R8 drop", 1'b0, 1'b0);
        chk("R8 dropped", 32'(stop_ok), 32'h0);

        // R6: mode 0, host input toggling during a long idle run
        do_wr("R2 mode0", 32'h0000_0000, 4'h1);
        for (int k = 0; k < 20; k++) idle_cyc("R6 host toggle", 1'b1, 1'(k % 3 == 0));

        // R9: bus reset with power management enabled keeps fields
        do_wr("R9 preset", 32'h0000_00B5, 4'h1);
        for (int k = 0; k < 10; k++) idle_cyc("R11 build run", 1'b1, 1'b1);
        pm_en = 1; bus_rst_n = 0;
        cyc("R9 write in reset", 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'h1);
        idle_cyc("R11 bus reset", 1'b1, 1'b1);
        chk("R9 kept", rd_data, 32'h0000_04B5);
        bus_rst_n = 1;
        for (int k = 0; k < 9; k++) idle_cyc("R11 restart", 1'b1, 1'b1);

        // R10: bus reset without power management clears
        pm_en = 0; bus_rst_n = 0;
        idle_cyc("R10 bus clear", 1'b1, 1'b1);
        chk("R10 cleared", rd_data, 32'h0000_0400);
        bus_rst_n = 1;
        do_wr("R10 preset", 32'h0000_00D2, 4'h1);

        // R10: global reset clears even with power management enabled
        pm_en = 1; glob_rst_n = 0;
        idle_cyc("R10 glob clear", 1'b1, 1'b1);
        chk("R10 glob cleared", rd_data, 32'h0000_0400);
        glob_rst_n = 1;
        for (int k = 0; k < 10; k++) idle_cyc("R5 after reset", 1'b1, 1'b1);

        summary();
    end

endmodule